// File: doc/BRIEF.md
# Dual-Style Host Register Port

This block lets an external 8-bit host processor read and write a small bank of internal registers. Two strap inputs configure it. A style input picks a strobe-based protocol with a read/write direction line and one data strobe, or a protocol with separate active-low read and write strobes. A bus-format input picks separate address and data pins, or a shared bus that carries the address first and then the data.

Every host pin is brought into the fast system clock through a two-flop synchronizer. All edges are found on the synchronized copies. The address is held in a register. Each completed host access produces exactly one single-cycle read or write strobe toward the register bank. During reads the block drives the data bus through a separate output-enable, so a pad tri-state can be built from `data_o` and `data_oe_o`.

In multiplexed form, a falling edge on the address-strobe / latch-enable pin captures the address from the low bits of the data bus. In separate form that pin is tied high, and the address pins are captured when an access begins.

Top module: `hostbus_slave`

## Requirements
- R1: With `bus_style_i` = 0, `rw_rd_i` is a direction line (1 = read) and `ds_wr_i` is the data strobe. With `bus_style_i` = 1, `rw_rd_i` is an active-low read strobe and `ds_wr_i` is an active-low write strobe. For example, the pattern `rw_rd_i` = 1 with a low pulse on `ds_wr_i` is a read in the first style and a write in the second.
- R2: With `muxed_i` = 0, the address is taken from `addr_i` when an access begins, and `as_ale_i` is held high. With `muxed_i` = 1, the address is taken from `data_i[ADDR_W-1:0]` on the falling edge of `as_ale_i`, and `addr_i` is ignored.
- R3: In direction/strobe style, `ds_wr_i` falling while `rw_rd_i` = 1 starts a read. `ds_wr_i` rising after a low phase with `rw_rd_i` = 0 completes a write of the data seen on `data_i` while the strobe was still low.
- R4: In separate-strobe style, `rw_rd_i` low with `ds_wr_i` high is a read. A write completes on the rising edge of `ds_wr_i` after a low phase in which `rw_rd_i` stayed high.
- R5: While `cs_n_i` stays high, no read or write strobe occurs and no register changes.
- R6: In direction/strobe style, `cs_n_i` may fall and rise in the same sample as `ds_wr_i`, and reads and writes still complete.
- R7: Each completed access gives exactly one `rd_stb_o` or `wr_stb_o` pulse, one clock wide. The two strobes are never high together.
- R8: `data_oe_o` rises in the cycle after `rd_stb_o`, with `data_o` holding the addressed register. It falls once the host read strobe or `cs_n_i` is released. It is low while a write strobe is issued.
- R9: In separate-strobe style, `rw_rd_i` and `ds_wr_i` falling together and rising together is ignored: there is no strobe, no output enable and no register change.
- R10: After reset all registers read 0, and `data_oe_o`, `rd_stb_o` and `wr_stb_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_style_i | input | 1 | 0: direction + data strobe, 1: separate read/write strobes |
| muxed_i | input | 1 | 0: separate address pins, 1: shared address/data bus |
| cs_n_i | input | 1 | Active-low chip select |
| as_ale_i | input | 1 | Address strobe / latch enable, falling edge latches (tie high when unused) |
| rw_rd_i | input | 1 | Direction line or active-low read strobe |
| ds_wr_i | input | 1 | Data strobe or active-low write strobe |
| addr_i | input | ADDR_W | Separate address pins |
| data_i | input | DATA_W | Data bus as seen at the pad input |
| data_o | output | DATA_W | Read data toward the pad |
| data_oe_o | output | 1 | Pad output enable during reads |
| rd_stb_o | output | 1 | One-cycle read strobe toward the register bank |
| wr_stb_o | output | 1 | One-cycle write strobe toward the register bank |

## Verification
When chip select is wired to the data strobe, the select qualification and the strobe edge reach the synchronized domain in the same sample. The design must then gate the start of an access and the completion of a write against one and the same cycle. The bench provokes this by moving `cs_n_i` and `ds_wr_i` in the same clock period, both on the falling and on the rising edge. It judges the result by counting exactly one strobe of the right kind and by reading the written value back. A related collision, both separate strobes falling in one sample, is driven the same way and must produce no strobe and no change.

// File: rtl/hostbus_slave_pkg.sv
package hostbus_slave_pkg;

  typedef enum logic {
    STYLE_DIR_STROBE = 1'b0,
    STYLE_SPLIT_RW   = 1'b1
  } bus_style_e;

  typedef struct packed {
    logic cs_n;
    logic ale;
    logic rwrd;
    logic dswr;
  } host_ctrl_t;

  localparam int CTRL_W = $bits(host_ctrl_t);

  // Read request level as decoded from one synchronized sample
  function automatic logic read_level(input logic style, input host_ctrl_t c);
    logic dir_rd;
    logic split_rd;
    dir_rd   = c.rwrd && !c.dswr;
    split_rd = !c.rwrd && c.dswr;
    return !c.cs_n && ((style == STYLE_SPLIT_RW) ? split_rd : dir_rd);
  endfunction

  // Write request level as decoded from one synchronized sample
  function automatic logic write_level(input logic style, input host_ctrl_t c);
    logic dir_wr;
    logic split_wr;
    dir_wr   = !c.rwrd && !c.dswr;
    split_wr = c.rwrd && !c.dswr;
    return !c.cs_n && ((style == STYLE_SPLIT_RW) ? split_wr : dir_wr);
  endfunction

  // Completion edge: the strobe pin returns high
  function automatic logic strobe_release(input host_ctrl_t now_s, input host_ctrl_t was_s);
    return now_s.dswr && !was_s.dswr;
  endfunction

endpackage

// File: rtl/hostbus_sync.sv
module hostbus_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= RST_VAL;
        else        stage[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= RST_VAL;
        else        stage[g] <= stage[g-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/hostbus_access_ctrl.sv
module hostbus_access_ctrl
  import hostbus_slave_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              style,
  input  logic              muxed,
  input  host_ctrl_t        ctrl_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] data_s,
  output host_ctrl_t        ctrl_p,
  output logic              evt_rd_start,
  output logic              evt_wr_done,
  output logic              evt_addr_latch,
  output logic              rd_hold,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              rd_stb,
  output logic              wr_stb
);
  logic [DATA_W-1:0] data_p;
  logic rd_now, rd_was, wr_now, wr_was;
  logic acc_start;
  logic ale_fall;
  logic [ADDR_W-1:0] addr_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_p <= '1;
      data_p <= '0;
    end else begin
      ctrl_p <= ctrl_s;
      data_p <= data_s;
    end
  end

  always_comb begin
    rd_now    = read_level(style, ctrl_s);
    rd_was    = read_level(style, ctrl_p);
    wr_now    = write_level(style, ctrl_s);
    wr_was    = write_level(style, ctrl_p);
    acc_start = (rd_now || wr_now) && !(rd_was || wr_was);
    ale_fall  = ctrl_p.ale && !ctrl_s.ale;
  end

  assign evt_rd_start   = rd_now && !rd_was;
  assign evt_wr_done    = wr_was && strobe_release(ctrl_s, ctrl_p);
  assign evt_addr_latch = muxed ? ale_fall : acc_start;
  assign rd_hold        = rd_now;
  assign addr_src       = muxed ? data_s[ADDR_W-1:0] : addr_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rd_stb  <= 1'b0;
      wr_stb  <= 1'b0;
    end else begin
      if (evt_addr_latch) addr_q <= addr_src;
      if (evt_wr_done)    wdata_q <= data_p;
      rd_stb <= evt_rd_start;
      wr_stb <= evt_wr_done;
    end
  end
endmodule

// File: rtl/hostbus_regfile.sv
module hostbus_regfile #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave
  import hostbus_slave_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_style_i,
  input  logic              muxed_i,
  input  logic              cs_n_i,
  input  logic              as_ale_i,
  input  logic              rw_rd_i,
  input  logic              ds_wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              rd_stb_o,
  output logic              wr_stb_o
);
  logic [CTRL_W-1:0] ctrl_raw;
  host_ctrl_t        ctrl_s;
  host_ctrl_t        ctrl_p;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rf_rdata;
  logic evt_rd_start, evt_wr_done, evt_addr_latch, rd_hold;
  logic rd_stb, wr_stb;
  logic [DATA_W-1:0] rdata_q;
  logic oe_q;

  // Named views for the bound checker
  logic cs_n_sync, cs_n_prev, rdpin_prev;

  hostbus_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTRL_W{1'b1}})) u_sync_ctrl (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n_i, as_ale_i, rw_rd_i, ds_wr_i}),
    .q(ctrl_raw)
  );
  hostbus_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_addr (
    .clk(clk), .rst_n(rst_n), .d(addr_i), .q(addr_s)
  );
  hostbus_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d(data_i), .q(data_s)
  );

  assign ctrl_s = host_ctrl_t'(ctrl_raw);

  hostbus_access_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .style(bus_style_i), .muxed(muxed_i),
    .ctrl_s(ctrl_s), .addr_s(addr_s), .data_s(data_s),
    .ctrl_p(ctrl_p),
    .evt_rd_start(evt_rd_start), .evt_wr_done(evt_wr_done),
    .evt_addr_latch(evt_addr_latch), .rd_hold(rd_hold),
    .addr_q(addr_q), .wdata_q(wdata_q),
    .rd_stb(rd_stb), .wr_stb(wr_stb)
  );

  hostbus_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(wr_stb), .addr(addr_q), .wdata(wdata_q), .rdata(rf_rdata)
  );

  // Read return path: capture on the strobe, drive until the host lets go
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      oe_q    <= 1'b0;
    end else if (rd_stb) begin
      rdata_q <= rf_rdata;
      oe_q    <= 1'b1;
    end else if (!rd_hold) begin
      oe_q    <= 1'b0;
    end
  end

  assign cs_n_sync  = ctrl_s.cs_n;
  assign cs_n_prev  = ctrl_p.cs_n;
  assign rdpin_prev = ctrl_p.rwrd;

  assign data_o    = rdata_q;
  assign data_oe_o = oe_q;
  assign rd_stb_o  = rd_stb;
  assign wr_stb_o  = wr_stb;
endmodule

// File: rtl/hostbus_slave_chk.sv
module hostbus_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_style_i,
  input logic rd_stb_o,
  input logic wr_stb_o,
  input logic data_oe_o,
  input logic cs_n_sync,
  input logic cs_n_prev,
  input logic rdpin_prev
);
  assert_rd_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_o |=> !rd_stb_o);
  assert_wr_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);
  assert_strobe_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb_o && wr_stb_o));
  assert_rd_needs_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_o |-> $past(!cs_n_sync));
  assert_wr_needs_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> $past(!cs_n_prev));
  assert_oe_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_o |=> data_oe_o);
  assert_oe_drop_on_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe_o && cs_n_sync && !rd_stb_o) |=> !data_oe_o);
  assert_no_oe_in_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> !data_oe_o);
  assert_split_wr_rd_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_o && bus_style_i) |-> $past(rdpin_prev));
endmodule

bind hostbus_slave hostbus_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_style_i(bus_style_i),
  .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o), .data_oe_o(data_oe_o),
  .cs_n_sync(cs_n_sync), .cs_n_prev(cs_n_prev), .rdpin_prev(rdpin_prev)
);

// File: tb/hostbus_slave_tb.sv
module hostbus_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_style = 1'b0, muxed = 1'b0, cs = 1'b1, ale = 1'b1, rw = 1'b1, ds = 1'b1;
  logic [3:0] addr_b = '0;
  logic [7:0] data_b = '0;
  logic [7:0] data_o;
  logic data_oe, rd_stb, wr_stb;

  int n_chk = 0, n_bad = 0, rd_cnt = 0, wr_cnt = 0;
  bit done = 0;
  logic [7:0] model [16];

  always #5 clk = ~clk;

  hostbus_slave dut_i (
    .clk(clk), .rst_n(rst_n), .bus_style_i(bus_style), .muxed_i(muxed),
    .cs_n_i(cs), .as_ale_i(ale), .rw_rd_i(rw), .ds_wr_i(ds),
    .addr_i(addr_b), .data_i(data_b),
    .data_o(data_o), .data_oe_o(data_oe), .rd_stb_o(rd_stb), .wr_stb_o(wr_stb)
  );

  always @(posedge clk) begin
    if (rd_stb) rd_cnt <= rd_cnt + 1;
    if (wr_stb) wr_cnt <= wr_cnt + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // One host access; nocs keeps chip select high throughout
  task automatic run_access(input logic st, input logic mx, input logic wr, input logic tie,
                            input logic nocs, input logic [3:0] a, input logic [7:0] d,
                            output logic [7:0] rdat, output logic oe_seen);
    bus_style = st; muxed = mx; tick(4);
    if (mx) begin
      data_b = {4'h0, a}; addr_b = ~a; ale = 1'b1; tick(3);
      ale = 1'b0; tick(3);
    end else begin
      addr_b = a; data_b = {4'hE, ~a};
    end
    data_b = wr ? d : 8'h6B;
    if (!st) begin
      rw = !wr; tick(2);
      if (!tie) begin cs = nocs; tick(3); end
      ds = 1'b0;
      if (tie) cs = nocs;
    end else begin
      cs = nocs; tick(3);
      if (wr) ds = 1'b0; else rw = 1'b0;
    end
    tick(8);
    rdat = data_o; oe_seen = data_oe;
    ds = 1'b1; rw = 1'b1;
    if (tie) cs = 1'b1;
    tick(3); cs = 1'b1; tick(6); ale = 1'b1; tick(2);
  endtask

  // Table: [15] style, [14] muxed, [13] write, [12] cs tied to ds, [11:8] addr, [7:0] data
  localparam int NV = 13;
  localparam logic [15:0] VEC [NV] = '{
    16'h235A, 16'h0300, 16'h6C3C, 16'h8C00, 16'hA781, 16'hE0FF,
    16'h4700, 16'hC000, 16'h3F42, 16'h1F00, 16'h7199, 16'h8100, 16'h4500
  };

  initial begin
    logic [7:0] rd;
    logic oe;
    int r0, w0;
    string req;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    tick(3);
    // R10: reset state
    chk("R10 oe", {31'b0, data_oe}, 0);
    chk("R10 strobes", {30'b0, rd_stb, wr_stb}, 0);
    rst_n = 1'b1; tick(3);
    run_access(0, 0, 0, 0, 0, 4'h3, 8'h00, rd, oe);
    chk("R10 reg reset value", {24'b0, rd}, 0);

    for (int v = 0; v < NV; v++) begin
      logic st, mx, wr, tie;
      logic [3:0] a;
      logic [7:0] d;
      {st, mx, wr, tie, a, d} = VEC[v];
      req = tie ? "R6" : (mx ? "R2" : (st ? "R4" : "R3"));
      r0 = rd_cnt; w0 = wr_cnt;
      run_access(st, mx, wr, tie, 0, a, d, rd, oe);
      if (wr) begin
        model[a] = d;
        chk({req, " R8 oe low in write"}, {31'b0, oe}, 0);
        chk("R7 one write strobe", wr_cnt - w0, 1);
        chk("R7 no read strobe", rd_cnt - r0, 0);
      end else begin
        chk({req, " read data"}, {24'b0, rd}, {24'b0, model[a]});
        chk("R8 oe during read", {31'b0, oe}, 1);
        chk("R7 one read strobe", rd_cnt - r0, 1);
        chk("R7 no write strobe", wr_cnt - w0, 0);
      end
    end

    // R1: same pin pattern (rw_rd high, ds_wr pulsed low) decodes per style
    r0 = rd_cnt; w0 = wr_cnt;
    run_access(0, 0, 0, 0, 0, 4'h3, 8'h00, rd, oe);
    chk("R1 direction style gives read", rd_cnt - r0, 1);
    chk("R1 direction style no write", wr_cnt - w0, 0);
    r0 = rd_cnt; w0 = wr_cnt;
    run_access(1, 0, 1, 0, 0, 4'h3, 8'hC7, rd, oe);
    model[3] = 8'hC7;
    chk("R1 split style gives write", wr_cnt - w0, 1);
    chk("R1 split style no read", rd_cnt - r0, 0);
    run_access(0, 0, 0, 0, 0, 4'h3, 8'h00, rd, oe);
    chk("R1 value written", {24'b0, rd}, {24'b0, model[3]});

    // R5: chip select never asserted
    r0 = rd_cnt; w0 = wr_cnt;
    run_access(0, 0, 1, 0, 1, 4'hF, 8'h11, rd, oe);
    run_access(1, 1, 0, 0, 1, 4'hF, 8'h00, rd, oe);
    chk("R5 no strobes without cs", (rd_cnt - r0) + (wr_cnt - w0), 0);
    chk("R5 no oe without cs", {31'b0, oe}, 0);
    run_access(1, 0, 0, 0, 0, 4'hF, 8'h00, rd, oe);
    chk("R5 register unchanged", {24'b0, rd}, {24'b0, model[15]});

    // R9: both split strobes low together
    bus_style = 1; muxed = 0; tick(4);
    addr_b = 4'h7; data_b = 8'h55; cs = 1'b0; tick(3);
    r0 = rd_cnt; w0 = wr_cnt;
    rw = 1'b0; ds = 1'b0; tick(8);
    chk("R9 no oe with both strobes low", {31'b0, data_oe}, 0);
    rw = 1'b1; ds = 1'b1; tick(8);
    cs = 1'b1; tick(6);
    chk("R9 no strobes", (rd_cnt - r0) + (wr_cnt - w0), 0);
    run_access(1, 0, 0, 0, 0, 4'h7, 8'h00, rd, oe);
    chk("R9 register unchanged", {24'b0, rd}, {24'b0, model[7]});

    // R8: chip select released while read strobe still low
    addr_b = 4'h7; cs = 1'b0; tick(3);
    rw = 1'b0; tick(8);
    chk("R8 oe set", {31'b0, data_oe}, 1);
    chk("R8 data driven", {24'b0, data_o}, {24'b0, model[7]});
    cs = 1'b1; tick(6);
    chk("R8 oe drops on cs release", {31'b0, data_oe}, 0);
    rw = 1'b1; tick(6);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule